// File: doc/BRIEF.md
# Addend-Tuned Timestamp Time Base

This block keeps a 64-bit system time for stamping packets and external events. A 32-bit fractional accumulator adds a programmable addend on every clock. Each carry out of the accumulator advances the system time by one count, and one count stands for 16 ns. Software trims the frequency by changing the addend. With the default addend the time advances on roughly 15 of every 16 clocks.

Software reaches the block through a simple 32-bit register port with single-cycle write strobes and a registered read. The port sets and reads the time and the addend, and it programs a 64-bit target time. The compare raises a sticky pending flag. Two external inputs, one for a master and one for a slave, each latch the system time on a rising edge when enabled. Three event flags record these conditions. Software clears each flag by writing a one to its bit. An interrupt output combines each flag with its enable.

Top module: `tsclk_unit`

## Requirements
- R1: After reset:
  - the addend reads 0xF0000029;
  - control, events, accumulator, both snapshots and the system time are zero;
  - the target reads all ones;
  - irq is low.
- R2: On every clock the accumulator adds the addend modulo 2^32. A carry out advances the 64-bit system time by one, including carries from the low word into the high word. Over 64 clocks with addend A, the time therefore advances by exactly 64*A/2^32 counts whenever that quantity is an integer.
- R3: A write to the time-low word (offset 0x10) only stages the value, and the system time keeps running unchanged by it. A later write to the time-high word (0x14) loads {high, staged low} in one step.
- R4: A read of time-low returns the low word and latches the high word at the same instant. A read of time-high (0x14) returns that latched value, even if the time has since been rewritten.
- R5: Event bit 1 (event register at 0x04) sets once the system time is greater than or equal to the target. The target is staged at 0x18 (low) and committed by a write to 0x1C (high). The bit stays set until a one is written to bit 1. If the condition still holds in the cycle of that write, the bit stays set.
- R6: With control bit 3 set, a rising edge on aux_mst copies the system time into the master snapshot (0x20 low, 0x24 high) and sets event bit 3. With control bit 2 set, aux_slv does the same into the slave snapshot (0x28, 0x2C) and sets event bit 2.
- R7: While its control enable bit is clear, an auxiliary input edge changes neither its snapshot nor its event bit.
- R8: While a snapshot's event bit is set, further edges on its input leave the snapshot unchanged. After the bit is cleared, the next edge captures again.
- R9: irq is high exactly when some event bit k (k = 1, 2, 3) is set together with control bit k.
- R10: Writing control (0x00) with bit 0 set does the following:
  - returns the time, accumulator, events and snapshots to zero;
  - returns the addend to 0xF0000029 and the target to all ones;
  - loads control bits 3:1 from the written data.

  Control bit 0 always reads as zero.
- R11: Registers are addressed on word-aligned offsets. The addend is at 0x08 and the accumulator at 0x0C, and both can be read and written. Read data appears on rdata in the cycle after rd_en, and writes take effect at the clock edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| aux_mst | input | 1 | Master auxiliary snapshot input, asynchronous |
| aux_slv | input | 1 | Slave auxiliary snapshot input, asynchronous |
| irq | output | 1 | Combined event interrupt |

## Verification
The bench builds the block with its defaults: 32-bit data, a 6-bit address, a two-stage synchronizer and the 0xF0000029 reset addend. With these widths, addend values that are simple binary fractions give rates that are exact over a 64-cycle window. A zero addend freezes time, so snapshot and compare values can be predicted exactly. Carries into the high word are reached by loading a time just below a word boundary rather than by counting up to it.

// File: rtl/tsclk_pkg.sv
package tsclk_pkg;
  // word indices (byte offset / 4)
  localparam int RG_CTRL   = 0;
  localparam int RG_EVT    = 1;
  localparam int RG_ADDEND = 2;
  localparam int RG_ACC    = 3;
  localparam int RG_TLO    = 4;
  localparam int RG_THI    = 5;
  localparam int RG_GLO    = 6;
  localparam int RG_GHI    = 7;
  localparam int RG_MLO    = 8;
  localparam int RG_MHI    = 9;
  localparam int RG_SLO    = 10;
  localparam int RG_SHI    = 11;
  // control and event bit positions (enable k gates event k)
  localparam int BIT_SRST  = 0;
  localparam int BIT_TGT   = 1;
  localparam int BIT_SLV   = 2;
  localparam int BIT_MST   = 3;
  localparam int EV_HI     = 3;
  localparam int N_AUX     = 2;
endpackage

// File: rtl/tsclk_accum.sv
module tsclk_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [W-1:0] addend,
  input  logic         acc_wr,
  input  logic [W-1:0] acc_wdata,
  output logic [W-1:0] acc_q,
  output logic         tick
);
  logic [W:0]   sum_w;
  logic [W-1:0] acc_d;

  always_comb begin
    sum_w = {1'b0, acc_q} + {1'b0, addend};
    tick  = sum_w[W] & ~acc_wr & ~soft_clr;
    if (soft_clr)    acc_d = '0;
    else if (acc_wr) acc_d = acc_wdata;
    else             acc_d = sum_w[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/tsclk_timebase.sv
module tsclk_timebase #(
  parameter int DW = 32,
  localparam int TW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          tick,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [DW-1:0] wdata,
  input  logic          lo_rd,
  output logic [TW-1:0] time_q,
  output logic [DW-1:0] hi_shadow
);
  logic [DW-1:0] stage_q, stage_d, shadow_d;
  logic [TW-1:0] time_d;

  always_comb begin
    stage_d  = stage_q;
    shadow_d = hi_shadow;
    time_d   = time_q + {{(TW-1){1'b0}}, tick};
    if (lo_wr) stage_d  = wdata;
    if (lo_rd) shadow_d = time_q[TW-1:DW];
    if (hi_wr) time_d   = {wdata, stage_q};
    if (soft_clr) begin
      stage_d  = '0;
      shadow_d = '0;
      time_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      hi_shadow <= '0;
      time_q    <= '0;
    end else begin
      stage_q   <= stage_d;
      hi_shadow <= shadow_d;
      time_q    <= time_d;
    end
  end
endmodule

// File: rtl/tsclk_aux_snap.sv
module tsclk_aux_snap #(
  parameter int TW   = 64,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          aux_in,
  input  logic          enable,
  input  logic          pending,
  input  logic [TW-1:0] time_in,
  output logic          capture,
  output logic [TW-1:0] snap_q
);
  logic [SYNC-1:0] sync_q, sync_d;
  logic            prev_q;
  logic [TW-1:0]   snap_d;

  always_comb begin
    sync_d  = {sync_q[SYNC-2:0], aux_in};
    capture = sync_q[SYNC-1] & ~prev_q & enable & ~pending & ~soft_clr;
    snap_d  = snap_q;
    if (capture)  snap_d = time_in;
    if (soft_clr) snap_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      snap_q <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC-1];
      snap_q <= snap_d;
    end
  end
endmodule

// File: rtl/tsclk_unit.sv
module tsclk_unit
  import tsclk_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 6,
  parameter int              SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ADDEND_RST = 32'hF000_0029
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              aux_mst,
  input  logic              aux_slv,
  output logic              irq
);
  localparam int TIME_W = 2 * DATA_W;
  localparam int IDX_W  = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              wr_ctrl, wr_evt, wr_add, wr_acc, wr_tlo, time_hi_wr, wr_glo, wr_ghi;
  logic              rd_tlo, soft_clr, tick, hit;
  logic [EV_HI:1]    ctrl_q, ctrl_d, evt_q, evt_d, evt_w1c, evt_set;
  logic [DATA_W-1:0] addend_q, addend_d, acc_q, hi_shadow, tgt_stage_q, tgt_stage_d, rdata_d;
  logic [TIME_W-1:0] sys_time, target_q, target_d, snap_mst, snap_slv;
  logic [TIME_W-1:0] snap_arr [N_AUX];
  logic [N_AUX-1:0]  cap_vec, aux_vec;

  assign idx        = addr[ADDR_W-1:2];
  assign aligned    = (addr[1:0] == 2'b00);
  assign wr_ctrl    = wr_en && aligned && idx == IDX_W'(RG_CTRL);
  assign wr_evt     = wr_en && aligned && idx == IDX_W'(RG_EVT);
  assign wr_add     = wr_en && aligned && idx == IDX_W'(RG_ADDEND);
  assign wr_acc     = wr_en && aligned && idx == IDX_W'(RG_ACC);
  assign wr_tlo     = wr_en && aligned && idx == IDX_W'(RG_TLO);
  assign time_hi_wr = wr_en && aligned && idx == IDX_W'(RG_THI);
  assign wr_glo     = wr_en && aligned && idx == IDX_W'(RG_GLO);
  assign wr_ghi     = wr_en && aligned && idx == IDX_W'(RG_GHI);
  assign rd_tlo     = rd_en && aligned && idx == IDX_W'(RG_TLO);
  assign soft_clr   = wr_ctrl && wdata[BIT_SRST];

  tsclk_accum #(.W(DATA_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .addend(addend_q),
    .acc_wr(wr_acc), .acc_wdata(wdata), .acc_q(acc_q), .tick(tick)
  );

  tsclk_timebase #(.DW(DATA_W)) u_time (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .tick(tick),
    .lo_wr(wr_tlo), .hi_wr(time_hi_wr), .wdata(wdata), .lo_rd(rd_tlo),
    .time_q(sys_time), .hi_shadow(hi_shadow)
  );

  // index 0: slave input, index 1: master input
  assign aux_vec = {aux_mst, aux_slv};
  for (genvar g = 0; g < N_AUX; g++) begin : g_aux
    tsclk_aux_snap #(.TW(TIME_W), .SYNC(SYNC_STAGES)) u_snap (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .aux_in(aux_vec[g]),
      .enable(ctrl_q[BIT_SLV+g]), .pending(evt_q[BIT_SLV+g]),
      .time_in(sys_time), .capture(cap_vec[g]), .snap_q(snap_arr[g])
    );
  end
  assign snap_slv = snap_arr[0];
  assign snap_mst = snap_arr[1];

  assign hit = (sys_time >= target_q);

  always_comb begin
    addend_d    = addend_q;
    ctrl_d      = ctrl_q;
    tgt_stage_d = tgt_stage_q;
    target_d    = target_q;
    if (wr_add)  addend_d    = wdata;
    if (wr_ctrl) ctrl_d      = wdata[EV_HI:1];
    if (wr_glo)  tgt_stage_d = wdata;
    if (wr_ghi)  target_d    = {wdata, tgt_stage_q};
    evt_w1c = wr_evt ? wdata[EV_HI:1] : '0;
    evt_set = {cap_vec[1], cap_vec[0], hit};
    evt_d   = (evt_q & ~evt_w1c) | evt_set;
    if (soft_clr) begin
      addend_d    = ADDEND_RST;
      tgt_stage_d = '0;
      target_d    = '1;
      evt_d       = '0;
    end
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_en) begin
      rdata_d = '0;
      if (aligned) begin
        case (int'(idx))
          RG_CTRL:   rdata_d = DATA_W'({ctrl_q, 1'b0});
          RG_EVT:    rdata_d = DATA_W'({evt_q, 1'b0});
          RG_ADDEND: rdata_d = addend_q;
          RG_ACC:    rdata_d = acc_q;
          RG_TLO:    rdata_d = sys_time[DATA_W-1:0];
          RG_THI:    rdata_d = hi_shadow;
          RG_GLO:    rdata_d = target_q[DATA_W-1:0];
          RG_GHI:    rdata_d = target_q[TIME_W-1:DATA_W];
          RG_MLO:    rdata_d = snap_mst[DATA_W-1:0];
          RG_MHI:    rdata_d = snap_mst[TIME_W-1:DATA_W];
          RG_SLO:    rdata_d = snap_slv[DATA_W-1:0];
          RG_SHI:    rdata_d = snap_slv[TIME_W-1:DATA_W];
          default:   rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addend_q    <= ADDEND_RST;
      ctrl_q      <= '0;
      evt_q       <= '0;
      tgt_stage_q <= '0;
      target_q    <= '1;
      rdata       <= '0;
    end else begin
      addend_q    <= addend_d;
      ctrl_q      <= ctrl_d;
      evt_q       <= evt_d;
      tgt_stage_q <= tgt_stage_d;
      target_q    <= target_d;
      rdata       <= rdata_d;
    end
  end

  assign irq = |(evt_q & ctrl_q);
endmodule

// File: rtl/tsclk_unit_chk.sv
module tsclk_unit_chk #(
  parameter int DATA_W = 32,
  localparam int TW = 2 * DATA_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_clr,
  input logic          time_hi_wr,
  input logic [TW-1:0] sys_time,
  input logic [3:1]    evt_q,
  input logic [3:1]    evt_w1c,
  input logic [3:1]    ctrl_q,
  input logic [TW-1:0] snap_mst,
  input logic [TW-1:0] snap_slv
);
  // R2
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(soft_clr) && !$past(time_hi_wr)) |->
      (sys_time == $past(sys_time) || sys_time == $past(sys_time) + 1'b1));

  // R5
  tgt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_q[1]) && !$past(soft_clr) && !$past(evt_w1c[1])) |-> evt_q[1]);

  // R7
  mst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_q[3]) |-> !$rose(evt_q[3]));

  // R7
  slv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_q[2]) |-> !$rose(evt_q[2]));

  // R8
  mst_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_q[3]) && !$past(soft_clr)) |-> $stable(snap_mst));

  // R8
  slv_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_q[2]) && !$past(soft_clr)) |-> $stable(snap_slv));

  // R10
  srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_clr) |-> (sys_time == '0 && evt_q == '0));
endmodule

bind tsclk_unit tsclk_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .time_hi_wr(time_hi_wr),
  .sys_time(sys_time), .evt_q(evt_q), .evt_w1c(evt_w1c), .ctrl_q(ctrl_q),
  .snap_mst(snap_mst), .snap_slv(snap_slv)
);

// File: tb/test_tsclk_unit.sv
`timescale 1ns/1ps
module test_tsclk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        aux_mst = 1'b0, aux_slv = 1'b0;
  logic        irq;
  int          checks = 0, errors = 0;
  logic [31:0] v, t0, t1;

  always #4 clk = ~clk;

  tsclk_unit i_tsclk_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .aux_mst(aux_mst), .aux_slv(aux_slv), .irq(irq)
  );

  // {addend, expected ticks over 64 cycles}
  localparam logic [63:0] RATE_VEC [5] = '{
    {32'h8000_0000, 32'd32}, {32'h4000_0000, 32'd16}, {32'h2000_0000, 32'd8},
    {32'hC000_0000, 32'd48}, {32'h0000_0000, 32'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 6'(r * 4); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int r, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = 6'(r * 4);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse_mst();
    @(negedge clk); aux_mst = 1'b1; repeat (6) @(negedge clk);
    aux_mst = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic pulse_slv();
    @(negedge clk); aux_slv = 1'b1; repeat (6) @(negedge clk);
    aux_slv = 1'b0; repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(2, v);  chk("R1 addend", v, 32'hF000_0029);
    rd(0, v);  chk("R1 ctrl", v, 32'h0);
    rd(1, v);  chk("R1 events", v, 32'h0);
    rd(7, v);  chk("R1 target hi", v, 32'hFFFF_FFFF);
    rd(8, v);  chk("R1 master snap", v, 32'h0);
    rd(10, v); chk("R1 slave snap", v, 32'h0);

    // freeze and zero time, then R2 rate table
    wr(2, 32'h0); wr(4, 32'h0); wr(5, 32'h0);
    rd(4, v); chk("R3 time zeroed", v, 32'h0);
    foreach (RATE_VEC[i]) begin
      wr(2, RATE_VEC[i][63:32]);
      rd(4, t0);
      repeat (62) @(negedge clk);
      rd(4, t1);
      chk("R2 rate", t1 - t0, RATE_VEC[i][31:0]);
    end

    // R11 accumulator access
    wr(3, 32'h1234_5678); rd(3, v); chk("R11 accumulator rw", v, 32'h1234_5678);

    // R2 carry into high word
    wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF); wr(5, 32'h3);
    wr(2, 32'h1); wr(2, 32'h0);
    rd(4, v); chk("R2 carry low", v, 32'h0);
    rd(5, v); chk("R2 carry high", v, 32'h4);

    // R3 staged low write
    wr(4, 32'hDEAD_0001);
    rd(4, v); chk("R3 low write staged", v, 32'h0);
    wr(5, 32'h7);
    rd(4, v); chk("R3 committed low", v, 32'hDEAD_0001);
    rd(5, v); chk("R3 committed high", v, 32'h7);

    // R4 coherent read
    rd(4, v);
    wr(4, 32'h0); wr(5, 32'h9);
    rd(5, v); chk("R4 latched high", v, 32'h7);
    rd(4, v); rd(5, v); chk("R4 new high", v, 32'h9);

    // R5 target compare
    wr(6, 32'h100); wr(7, 32'h9);
    rd(1, v); chk("R5 below target", v, 32'h0);
    wr(4, 32'h100); wr(5, 32'h9);
    rd(1, v); chk("R5 equal target", v, 32'h2);
    chk("R9 no irq when disabled", {31'b0, irq}, 32'h0);
    wr(0, 32'h2);
    chk("R9 irq target", {31'b0, irq}, 32'h1);
    wr(1, 32'h2);
    rd(1, v); chk("R5 set wins over clear", v, 32'h2);
    wr(6, 32'h0); wr(7, 32'hA);
    rd(1, v); chk("R5 sticky", v, 32'h2);
    wr(1, 32'h2);
    rd(1, v); chk("R5 cleared", v, 32'h0);
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);

    // R6 master snapshot
    wr(0, 32'h8);
    pulse_mst();
    rd(1, v); chk("R6 master event", v, 32'h8);
    rd(8, v); chk("R6 master lo", v, 32'h100);
    rd(9, v); chk("R6 master hi", v, 32'h9);
    chk("R9 irq master", {31'b0, irq}, 32'h1);

    // R7 disabled slave ignored
    pulse_slv();
    rd(1, v);  chk("R7 slave event off", v, 32'h8);
    rd(10, v); chk("R7 slave snap off", v, 32'h0);

    // R8 lock while pending
    wr(4, 32'h200); wr(5, 32'h9);
    pulse_mst();
    rd(8, v); chk("R8 locked", v, 32'h100);
    wr(1, 32'h8);
    rd(1, v); chk("R8 flag cleared", v, 32'h0);
    pulse_mst();
    rd(8, v); chk("R8 recapture", v, 32'h200);

    // R6 slave snapshot
    wr(1, 32'h8);
    wr(0, 32'h4);
    pulse_slv();
    rd(1, v);  chk("R6 slave event", v, 32'h4);
    rd(10, v); chk("R6 slave lo", v, 32'h200);
    rd(11, v); chk("R6 slave hi", v, 32'h9);
    chk("R9 irq slave", {31'b0, irq}, 32'h1);

    // R10 soft reset
    wr(2, 32'h5);
    wr(0, 32'h5);
    rd(2, v);  chk("R10 addend", v, 32'hF000_0029);
    rd(1, v);  chk("R10 events", v, 32'h0);
    rd(10, v); chk("R10 snapshot", v, 32'h0);
    rd(0, v);  chk("R10 ctrl", v, 32'h4);
    rd(7, v);  chk("R10 target", v, 32'hFFFF_FFFF);
    rd(4, v);  chk("R10 time restarted", {31'b0, v < 32'd32}, 32'h1);
    rd(5, v);  chk("R10 time high", v, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule